// File: doc/BRIEF.md
# System Controller with Dual Timers

This block is a small memory-mapped control peripheral for a 32-bit register bus that only performs full-word accesses. It holds two identical timers that count upward toward a programmable compare value, each raising a one-cycle interrupt pulse on its own line when the count meets the compare value. A timer either stops on a match, clearing its own enable bit, or wraps to zero and keeps going.

Around the timers sit a general-purpose scratch register and a debug-lock register that only store what is written. There is also a fixed status word for a configuration port, and read-only identity words: system identifier, clock frequency, capability flags and GPIO strapping. A write to the system-reset register produces a one-cycle reset request to the rest of the chip. Software learns of accesses to unmapped addresses and of writes to read-only words through a one-cycle error strobe.

An access is a single cycle with `bus_sel` high. Read data and the error strobe are registered and appear one cycle after the access. Writes take effect at the clock edge of the access.

Top module: `sysctl_top`

## Requirements
- R1: After reset, the timer registers, scratch and debug-lock registers read 0. The configuration status reads 0x00000001 (ready). The clock-frequency word reads parameter CLK_HZ. Capabilities read 0x00000000, system ID reads 0x10014D31 and GPIO strapping reads 0x00000001.
- R2: Word index = byte address / 4. Timer t uses index 3t for control, 3t+1 for compare and 3t+2 for counter. After the timers come scratch (6), configuration status (7), debug lock (8), system reset (9), clock frequency (10), capabilities (11), system ID (12) and GPIO strapping (13). A value written to scratch or debug lock reads back unchanged.
- R3: Control bit 0 enables and control bit 1 selects auto-restart. The timer is enabled from counter value C with compare value K ≥ C and bit 1 clear. It then counts one per cycle, and its interrupt is high K−C+1 cycles after the enabling write. After that the counter holds K and control reads 0.
- R4: A timer interrupt lasts exactly one cycle after a single match.
- R5: With auto-restart set and K ≥ 1, the counter wraps to 0 on a match and keeps counting. Interrupt pulses then repeat every K+1 cycles, and control keeps reading 3.
- R6: Clearing the enable bit freezes the counter. Setting it again resumes counting from the held value.
- R7: Writes to clock frequency, capabilities, system ID and GPIO strapping leave their values unchanged and raise the error strobe.
- R8: A read of an unmapped index (14 and above) returns 0 and raises the error strobe. A write there raises the error strobe.
- R9: A write to the system-reset register drives `rst_req` high for exactly one cycle, one cycle after the write.
- R10: The two timers run independently. Activity in one never produces an interrupt on the other.
- R11: The error strobe stays low for reads of mapped registers and for writes to writable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error strobe |
| irq | output | NTIMER | Per-timer interrupt pulses |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact cycle distance from the enabling write to the first interrupt. An off-by-one in the match compare or in the reload value would show up as a shifted or stretched period. It checks that a one-shot timer has cleared its enable bit and parked at the compare value. A design that kept counting would read back a larger count or a set enable. It stops a free-running timer and reads the counter twice, then restarts it from that held value. A design that cleared the counter on enable would produce a longer delay. Writes to the read-only words and accesses to unmapped indices are checked for both the error strobe and unchanged data, so that a decoder that let the write land or returned stale read data is exposed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW = 32;
    localparam int REGS_PER_TIMER = 3;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_TCTL,
        RK_TCMP,
        RK_TCNT,
        RK_SCRATCH,
        RK_CFGSTAT,
        RK_DBGLOCK,
        RK_SYSRST,
        RK_CLKHZ,
        RK_CAPS,
        RK_SYSID,
        RK_GPIOIN
    } reg_kind_e;

    typedef struct packed {
        logic auto_rs;
        logic en;
    } tmr_ctl_t;

    typedef struct packed {
        reg_kind_e kind;
        logic [7:0] tsel;
    } dec_t;

    function automatic dec_t decode_idx(input int idx, input int ntimer);
        dec_t d;
        int off;
        d.kind = RK_NONE;
        d.tsel = '0;
        if (idx < REGS_PER_TIMER * ntimer) begin
            d.tsel = 8'(idx / REGS_PER_TIMER);
            case (idx % REGS_PER_TIMER)
                0:       d.kind = RK_TCTL;
                1:       d.kind = RK_TCMP;
                default: d.kind = RK_TCNT;
            endcase
        end else begin
            off = idx - REGS_PER_TIMER * ntimer;
            case (off)
                0:       d.kind = RK_SCRATCH;
                1:       d.kind = RK_CFGSTAT;
                2:       d.kind = RK_DBGLOCK;
                3:       d.kind = RK_SYSRST;
                4:       d.kind = RK_CLKHZ;
                5:       d.kind = RK_CAPS;
                6:       d.kind = RK_SYSID;
                7:       d.kind = RK_GPIOIN;
                default: d.kind = RK_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic is_read_only(input reg_kind_e k);
        return (k == RK_CLKHZ) || (k == RK_CAPS) ||
               (k == RK_SYSID) || (k == RK_GPIOIN);
    endfunction

endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl,
    input  logic          wr_cmp,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    output tmr_ctl_t      ctl_q,
    output logic [DW-1:0] cmp_q,
    output logic [DW-1:0] cnt_q,
    output logic          irq
);

    logic hit;
    assign hit = ctl_q.en && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmp_q <= '0;
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= hit;
            if (hit) begin
                if (ctl_q.auto_rs) begin
                    cnt_q <= '0;
                end else begin
                    ctl_q.en <= 1'b0;
                end
            end else if (ctl_q.en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            // software access overrides the hardware update in the same cycle
            if (wr_cmp) cmp_q <= wdata;
            if (wr_cnt) cnt_q <= wdata;
            if (wr_ctl) ctl_q <= tmr_ctl_t'(wdata[1:0]);
        end
    end

endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NTIMER = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    input  logic              we,
    output reg_kind_e         kind,
    output logic [7:0]        tsel,
    output logic              err_next
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    dec_t d;

    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        d        = decode_idx(int'(idx), NTIMER);
        kind     = d.kind;
        tsel     = d.tsel;
        err_next = sel && ((d.kind == RK_NONE) || (we && is_read_only(d.kind)));
    end

endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter int          NTIMER = 2,
    parameter logic [31:0] CLK_HZ = 32'd100_000_000,
    parameter logic [31:0] SYS_ID = 32'h10014D31,
    parameter logic [31:0] CAPS   = 32'h00000000,
    parameter logic [31:0] STRAP  = 32'h00000001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [NTIMER-1:0] irq,
    output logic              rst_req
);

    localparam logic [31:0] CFG_READY = 32'h00000001;

    reg_kind_e   kind;
    logic [7:0]  tsel;
    logic        err_next;

    logic [NTIMER-1:0]         wr_ctl, wr_cmp, wr_cnt;
    logic [NTIMER-1:0]         t_en, t_auto;
    logic [NTIMER-1:0][DW-1:0] t_cmp, t_cnt;

    logic [DW-1:0] scratch_q, dbglock_q, rd_mux;
    logic          wr_any;

    assign wr_any = bus_sel && bus_we;

    sysctl_decode #(.ADDR_W(ADDR_W), .NTIMER(NTIMER)) u_dec (
        .addr     (bus_addr),
        .sel      (bus_sel),
        .we       (bus_we),
        .kind     (kind),
        .tsel     (tsel),
        .err_next (err_next)
    );

    for (genvar i = 0; i < NTIMER; i++) begin : g_tmr
        tmr_ctl_t c;
        assign wr_ctl[i] = wr_any && (kind == RK_TCTL) && (tsel == 8'(i));
        assign wr_cmp[i] = wr_any && (kind == RK_TCMP) && (tsel == 8'(i));
        assign wr_cnt[i] = wr_any && (kind == RK_TCNT) && (tsel == 8'(i));
        sysctl_timer u_tmr (
            .clk    (clk),
            .rst    (rst),
            .wr_ctl (wr_ctl[i]),
            .wr_cmp (wr_cmp[i]),
            .wr_cnt (wr_cnt[i]),
            .wdata  (bus_wdata),
            .ctl_q  (c),
            .cmp_q  (t_cmp[i]),
            .cnt_q  (t_cnt[i]),
            .irq    (irq[i])
        );
        assign t_en[i]   = c.en;
        assign t_auto[i] = c.auto_rs;
    end

    always_comb begin
        rd_mux = '0;
        case (kind)
            RK_TCTL:    rd_mux = {30'd0, t_auto[tsel], t_en[tsel]};
            RK_TCMP:    rd_mux = t_cmp[tsel];
            RK_TCNT:    rd_mux = t_cnt[tsel];
            RK_SCRATCH: rd_mux = scratch_q;
            RK_CFGSTAT: rd_mux = CFG_READY;
            RK_DBGLOCK: rd_mux = dbglock_q;
            RK_CLKHZ:   rd_mux = CLK_HZ;
            RK_CAPS:    rd_mux = CAPS;
            RK_SYSID:   rd_mux = SYS_ID;
            RK_GPIOIN:  rd_mux = STRAP;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            dbglock_q <= '0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            bus_err <= err_next;
            rst_req <= wr_any && (kind == RK_SYSRST);
            if (bus_sel && !bus_we) bus_rdata <= rd_mux;
            if (wr_any && kind == RK_SCRATCH) scratch_q <= bus_wdata;
            if (wr_any && kind == RK_DBGLOCK) dbglock_q <= bus_wdata;
        end
    end

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk #(
    parameter int ADDR_W = 6,
    parameter int NTIMER = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_sel,
    input logic                    bus_we,
    input logic [NTIMER-1:0]       wr_ctl,
    input logic [NTIMER-1:0]       wr_cnt,
    input logic [NTIMER-1:0]       t_en,
    input logic [NTIMER-1:0]       t_auto,
    input logic [NTIMER-1:0][31:0] t_cmp,
    input logic [NTIMER-1:0][31:0] t_cnt,
    input logic [NTIMER-1:0]       irq,
    input logic                    bus_err,
    input logic                    rst_req
);

    for (genvar i = 0; i < NTIMER; i++) begin : g_a
        a_r3_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
            (t_en[i] && t_cnt[i] == t_cmp[i] && !t_auto[i] && !wr_ctl[i]) |=> !t_en[i]);
        a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
            (t_en[i] && t_cnt[i] == t_cmp[i] && t_auto[i] && !wr_ctl[i] && !wr_cnt[i])
            |=> (t_en[i] && t_cnt[i] == 32'd0));
        a_r6_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
            (!t_en[i] && !wr_cnt[i]) |=> $stable(t_cnt[i]));
        a_r4_irq_from_match: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(t_en[i] && t_cnt[i] == t_cmp[i]));
    end

    a_r8_err_needs_access: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel));
    a_r9_rstreq_from_write: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(bus_sel && bus_we));

endmodule

bind sysctl_top sysctl_chk #(.ADDR_W(ADDR_W), .NTIMER(NTIMER)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .wr_ctl  (wr_ctl),
    .wr_cnt  (wr_cnt),
    .t_en    (t_en),
    .t_auto  (t_auto),
    .t_cmp   (t_cmp),
    .t_cnt   (t_cnt),
    .irq     (irq),
    .bus_err (bus_err),
    .rst_req (rst_req)
);

// File: tb/tb_sysctl_top.sv
module tb_sysctl_top;

    localparam int I_CTL0 = 0, I_CMP0 = 1, I_CNT0 = 2;
    localparam int I_SCR = 6, I_CFG = 7, I_DBG = 8, I_RST = 9;
    localparam int I_CLK = 10, I_CAPS = 11, I_ID = 12, I_GPIO = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, rst_req;
    logic [1:0]  irq;

    int total = 0, bad = 0;
    logic last_rst;

    sysctl_top dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq(irq), .rst_req(rst_req)
    );

    always #2.5 clk = ~clk;

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        e = bus_err; last_rst = rst_req;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'(idx * 4);
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata; e = bus_err;
        bus_sel = 1'b0;
    endtask

    function automatic int exp_delay(input int c, input int k);
        return k - c + 1;
    endfunction

    // enable one-shot timer t from c toward k; returns cycles to irq and stray irq on other timer
    task automatic run_oneshot(input int t, input int c, input int k, output int n, output logic stray);
        logic e;
        wr(3*t+1, 32'(k), e);
        wr(3*t+2, 32'(c), e);
        wr(3*t, 32'd1, e);
        n = 0; stray = 1'b0;
        while (!irq[t]) begin
            @(negedge clk);
            n++;
            if (irq[1-t]) stray = 1'b1;
        end
    endtask

    initial begin
        logic [31:0] d, v1, v2;
        logic e;
        int n, m;
        logic stray;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 / R11: reset values, no error on mapped reads
        rd(I_CTL0, d, e); chk("R1 ctl0", d, 0); chk("R11 err on read", 32'(e), 0);
        rd(I_CMP0, d, e); chk("R1 cmp0", d, 0);
        rd(I_CNT0, d, e); chk("R1 cnt0", d, 0);
        rd(I_SCR, d, e);  chk("R1 scratch", d, 0);
        rd(I_CFG, d, e);  chk("R1 cfg status", d, 32'h1);
        rd(I_DBG, d, e);  chk("R1 dbg lock", d, 0);
        rd(I_CLK, d, e);  chk("R1 clk hz", d, 32'd100_000_000);
        rd(I_CAPS, d, e); chk("R1 caps", d, 0);
        rd(I_ID, d, e);   chk("R1 sysid", d, 32'h10014D31);
        rd(I_GPIO, d, e); chk("R1 strap", d, 32'h1); chk("R11 err", 32'(e), 0);
        chk("R4 irq idle", 32'(irq), 0);

        // R2: random scratch / debug-lock readback
        for (int i = 0; i < 8; i++) begin
            v1 = $urandom();
            wr((i % 2) ? I_DBG : I_SCR, v1, e);
            chk("R11 err on write", 32'(e), 0);
            rd((i % 2) ? I_DBG : I_SCR, d, e);
            chk("R2 readback", d, v1);
        end

        // R3 / R4: directed one-shot corner (C == K)
        run_oneshot(0, 7, 7, n, stray);
        chk("R3 delay c==k", 32'(n), 32'(exp_delay(7, 7)));
        @(negedge clk); chk("R4 irq width", 32'(irq[0]), 0);
        rd(I_CTL0, d, e); chk("R3 enable cleared", d, 0);
        rd(I_CNT0, d, e); chk("R3 counter holds", d, 7);

        // R3 / R10: random one-shots on both timers
        for (int i = 0; i < 8; i++) begin
            int t, c, k;
            t = int'($urandom() % 2);
            c = int'($urandom() % 20);
            k = c + int'($urandom() % 30);
            run_oneshot(t, c, k, n, stray);
            chk("R3 delay", 32'(n), 32'(exp_delay(c, k)));
            chk("R10 no stray irq", 32'(stray), 0);
            @(negedge clk); chk("R4 irq width", 32'(irq[t]), 0);
            rd(3*t+2, d, e); chk("R3 parked", d, 32'(k));
        end

        // R5: auto-restart period on timer 1
        wr(4, 32'd5, e); wr(5, 32'd0, e); wr(3, 32'd3, e);
        while (!irq[1]) @(negedge clk);
        m = 0;
        do begin @(negedge clk); m++; end while (!irq[1]);
        chk("R5 period", 32'(m), 32'd6);
        m = 0;
        do begin @(negedge clk); m++; end while (!irq[1]);
        chk("R5 period 2", 32'(m), 32'd6);
        rd(3, d, e); chk("R5 ctl kept", d, 32'd3);

        // R6: stop, hold, resume
        wr(3, 32'd0, e);
        rd(5, v1, e);
        repeat (4) @(negedge clk);
        rd(5, v2, e);
        chk("R6 frozen", v2, v1);
        run_oneshot(1, int'(v1), int'(v1) + 3, n, stray);
        // run_oneshot rewrites the same counter value, so also test plain resume
        wr(4, v1 + 32'd3, e); wr(3, 32'd1, e);
        n = 0;
        while (!irq[1]) begin @(negedge clk); n++; end
        chk("R6 resume from held", 32'(n), 32'd1);

        // R7: read-only writes
        wr(I_ID, 32'hFFFF_FFFF, e);   chk("R7 err sysid", 32'(e), 1);
        rd(I_ID, d, e);               chk("R7 sysid kept", d, 32'h10014D31);
        wr(I_CLK, 32'h0, e);          chk("R7 err clk", 32'(e), 1);
        rd(I_CLK, d, e);              chk("R7 clk kept", d, 32'd100_000_000);
        wr(I_CAPS, 32'hA5A5, e);      chk("R7 err caps", 32'(e), 1);
        rd(I_CAPS, d, e);             chk("R7 caps kept", d, 0);
        wr(I_GPIO, 32'h0, e);         chk("R7 err strap", 32'(e), 1);
        rd(I_GPIO, d, e);             chk("R7 strap kept", d, 1);

        // R8: unmapped
        rd(I_SCR, d, e);
        rd(14, d, e); chk("R8 unmapped data", d, 0); chk("R8 unmapped read err", 32'(e), 1);
        wr(15, 32'h1234, e); chk("R8 unmapped write err", 32'(e), 1);
        @(negedge clk); chk("R8 err one cycle", 32'(bus_err), 0);

        // R9: reset request
        chk("R9 idle", 32'(rst_req), 0);
        wr(I_RST, 32'd1, e); chk("R9 pulse", 32'(last_rst), 1);
        chk("R11 err on rst write", 32'(e), 0);
        @(negedge clk); chk("R9 pulse width", 32'(rst_req), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule